// File: doc/BRIEF.md
# Scrolling Tile Background Renderer

This block paints a monochrome background into a 96x64 one-bit frame buffer kept in shared RAM. The background is a grid of 8x8 tiles. A tile-index grid sits in RAM just past the frame buffer. The bitmaps of the tiles live at a 24-bit tile-set base. On a start strobe the block walks the frame buffer one byte at a time. For each byte it looks up the tile index under each needed pixel, fetches the tile strips, and merges two strips when the vertical offset is not tile aligned. It can complement the result, then writes the byte. A one-cycle done pulse marks the end of the frame.

The horizontal and vertical view offsets are written through two strobed register ports. Each written value is always stored and read back. The effective view origin takes the new value only when the whole 96x64 view would still lie inside the map at the map size selected at that moment. A later change of map size does not re-check the origin. The renderer never wraps around the map.

Top module: `tile_map_render`

## Requirements
- R1: After reset the memory port is idle (mem_req low), done and busy are low, both scroll read-backs are 0 and the effective origin is (0,0).
- R2: map_size selects the grid size in tiles (columns x rows): 0 gives 12x16, 1 gives 16x12, 2 gives 24x8 and 3 gives 24x16.
- R3: The tile index for tile column tx and tile row ty is read from FB_BASE + 0x360 + ty*columns + tx.
- R4: The strip for pixel column x of a tile with index i is read from tile_base + 8*i + (x mod 8).
- R5: Frame byte at FB_BASE + page*96 + col holds the screen pixels of column col and rows 8*page to 8*page+7, with bit 0 holding the top row and bit 7 the bottom row. Each tile strip likewise holds its top pixel in bit 0.
- R6: When invert is high at the start strobe, every written pixel is the complement of the map pixel.
- R7: A scroll write stores the 7-bit value, and it appears on the matching read-back output one cycle later, whether or not it is in range.
- R8: A horizontal write v moves the effective x origin only if v+96 <= 8*columns. A vertical write v moves the effective y origin only if v+64 <= 8*rows. Otherwise the previous origin stays.
- R9: Changing map_size after a scroll write leaves the effective origin unchanged, and a later render uses the new column count with that origin.
- R10: For a vertical offset that is not a multiple of 8, each byte combines strips of two vertically adjacent tiles. With an in-range origin, no tile-index read falls outside the map.
- R11: A render writes exactly 768 bytes, all inside FB_BASE to FB_BASE+0x2FF. done is high for exactly one cycle after the last write.
- R12: Read data on mem_rdata is taken one cycle after the read request. mem_we is high only together with mem_req.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins one frame render when idle |
| map_size | input | 2 | Grid size code |
| tile_base | input | 24 | Tile bitmap base address |
| invert | input | 1 | Complement rendered pixels |
| scroll_x_wr | input | 1 | Horizontal offset write strobe |
| scroll_x_data | input | 7 | Horizontal offset write value |
| scroll_y_wr | input | 1 | Vertical offset write strobe |
| scroll_y_data | input | 7 | Vertical offset write value |
| scroll_x | output | 7 | Stored horizontal offset |
| scroll_y | output | 7 | Stored vertical offset |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 24 | Access address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, one cycle after request |
| busy | output | 1 | Render in progress |
| done | output | 1 | One-cycle end-of-frame pulse |

## Verification
Every byte of the frame is compared with an image the bench derives pixel by pixel from its own map and tile contents. This is done for all four grid sizes. A zero offset separates addressing faults from merge faults. An unaligned offset of (13,21) with inversion exercises the two-strip merge and complement paths. Boundary writes (32 and 40 on the 16-wide grid, 96 and 97 on the 24x8 grid, 32 and 33 vertically) distinguish an accepted origin from a rejected one. A size change after a valid write shows that the origin is not re-checked.

// File: rtl/tmap_pkg.sv
package tmap_pkg;

   typedef enum logic [2:0] {
      ST_IDLE, ST_MAP_A, ST_TIL_A, ST_MAP_B, ST_TIL_B, ST_WRITE, ST_DONE
   } seq_st_t;

   // Grid width in tiles for a size code.
   function automatic int unsigned map_cols(input logic [1:0] code);
      case (code)
         2'd0:    return 12;
         2'd1:    return 16;
         default: return 24;
      endcase
   endfunction

   // Grid height in tiles for a size code.
   function automatic int unsigned map_rows(input logic [1:0] code);
      case (code)
         2'd0:    return 16;
         2'd1:    return 12;
         2'd2:    return 8;
         default: return 16;
      endcase
   endfunction

endpackage

// File: rtl/tmap_scroll_gate.sv
// Stores raw scroll writes; moves the effective origin only for in-range values.
module tmap_scroll_gate
   import tmap_pkg::*;
#(
   parameter int SCR_W = 96,
   parameter int SCR_H = 64,
   parameter int SW    = 7
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [1:0]    map_size,
   input  logic          wr_x,
   input  logic [SW-1:0] wdata_x,
   input  logic          wr_y,
   input  logic [SW-1:0] wdata_y,
   output logic [SW-1:0] reg_x,
   output logic [SW-1:0] reg_y,
   output logic [SW-1:0] org_x,
   output logic [SW-1:0] org_y
);
   logic fit_x, fit_y;

   always_comb begin
      fit_x = (32'(wdata_x) + 32'(SCR_W)) <= map_cols(map_size) * 32'd8;
      fit_y = (32'(wdata_y) + 32'(SCR_H)) <= map_rows(map_size) * 32'd8;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         reg_x <= '0;
         reg_y <= '0;
         org_x <= '0;
         org_y <= '0;
      end else begin
         if (wr_x) begin
            reg_x <= wdata_x;
            if (fit_x) org_x <= wdata_x;
         end
         if (wr_y) begin
            reg_y <= wdata_y;
            if (fit_y) org_y <= wdata_y;
         end
      end
   end
endmodule

// File: rtl/tmap_pixel_merge.sv
// Joins two vertical strips at a bit offset and optionally complements.
module tmap_pixel_merge (
   input  logic [7:0] lo_byte,
   input  logic [7:0] hi_byte,
   input  logic [2:0] shift,
   input  logic       invert,
   output logic [7:0] merged
);
   logic [15:0] pair_sh;

   always_comb pair_sh = {hi_byte, lo_byte} >> shift;

   for (genvar b = 0; b < 8; b++) begin : g_bit
      assign merged[b] = pair_sh[b] ^ invert;
   end
endmodule

// File: rtl/tmap_render_seq.sv
// Walks the frame buffer byte by byte, issuing map, tile and frame accesses.
module tmap_render_seq
   import tmap_pkg::*;
#(
   parameter int                 ADDR_W  = 24,
   parameter logic [ADDR_W-1:0]  FB_BASE = 'h1000,
   parameter int                 MAP_OFS = 'h360,
   parameter int                 SCR_W   = 96,
   parameter int                 SCR_H   = 64,
   parameter int                 SW      = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [1:0]        map_size,
   input  logic [ADDR_W-1:0] tile_base,
   input  logic              invert,
   input  logic [SW-1:0]     org_x,
   input  logic [SW-1:0]     org_y,
   input  logic [7:0]        mem_rdata,
   input  logic [7:0]        merged,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [7:0]        lo_byte,
   output logic [7:0]        hi_byte,
   output logic [2:0]        shift,
   output logic              inv_q,
   output logic              busy,
   output logic              done
);
   localparam int PAGES = SCR_H / 8;
   localparam int COLW  = $clog2(SCR_W);
   localparam int PGW   = $clog2(PAGES);
   localparam int XW    = $clog2((1 << SW) + SCR_W);
   localparam int YW    = $clog2((1 << SW) + SCR_H);
   localparam logic [ADDR_W-1:0] MAP_BASE = FB_BASE + ADDR_W'(MAP_OFS);

   seq_st_t             state;
   logic [COLW-1:0]     col;
   logic [PGW-1:0]      pg;
   logic [4:0]          cols_q;
   logic [ADDR_W-1:0]   tile_q;
   logic [SW-1:0]       ox_q, oy_q;
   logic [7:0]          strip_a;

   logic [XW-1:0]       pix_x;
   logic [YW-1:0]       pix_y;
   logic [YW-4:0]       ty_sel;
   logic [ADDR_W-1:0]   map_addr, tile_addr, fb_addr;
   logic                last_byte;

   always_comb begin
      pix_x     = XW'(ox_q) + XW'(col);
      pix_y     = YW'(oy_q) + YW'({pg, 3'b000});
      shift     = pix_y[2:0];
      ty_sel    = (state == ST_MAP_B) ? pix_y[YW-1:3] + 1'b1 : pix_y[YW-1:3];
      map_addr  = MAP_BASE + ADDR_W'(ty_sel) * ADDR_W'(cols_q) + ADDR_W'(pix_x[XW-1:3]);
      tile_addr = tile_q + ADDR_W'({mem_rdata, 3'b000}) + ADDR_W'(pix_x[2:0]);
      fb_addr   = FB_BASE + ADDR_W'(pg) * ADDR_W'(SCR_W) + ADDR_W'(col);
      last_byte = (col == COLW'(SCR_W - 1)) && (pg == PGW'(PAGES - 1));
      lo_byte   = (shift == 3'd0) ? mem_rdata : strip_a;
      hi_byte   = mem_rdata;
      busy      = (state != ST_IDLE);
      done      = (state == ST_DONE);
      mem_we    = (state == ST_WRITE);
      mem_req   = (state == ST_MAP_A) || (state == ST_TIL_A) || (state == ST_MAP_B)
               || (state == ST_TIL_B) || (state == ST_WRITE);
      case (state)
         ST_MAP_A, ST_MAP_B: mem_addr = map_addr;
         ST_TIL_A, ST_TIL_B: mem_addr = tile_addr;
         ST_WRITE:           mem_addr = fb_addr;
         default:            mem_addr = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         col     <= '0;
         pg      <= '0;
         cols_q  <= '0;
         tile_q  <= '0;
         ox_q    <= '0;
         oy_q    <= '0;
         inv_q   <= 1'b0;
         strip_a <= '0;
      end else begin
         case (state)
            ST_IDLE: if (start) begin
               cols_q <= 5'(map_cols(map_size));
               tile_q <= tile_base;
               ox_q   <= org_x;
               oy_q   <= org_y;
               inv_q  <= invert;
               col    <= '0;
               pg     <= '0;
               state  <= ST_MAP_A;
            end
            ST_MAP_A: state <= ST_TIL_A;
            ST_TIL_A: state <= (shift == 3'd0) ? ST_WRITE : ST_MAP_B;
            ST_MAP_B: begin
               strip_a <= mem_rdata;
               state   <= ST_TIL_B;
            end
            ST_TIL_B: state <= ST_WRITE;
            ST_WRITE: begin
               if (last_byte) begin
                  state <= ST_DONE;
               end else begin
                  state <= ST_MAP_A;
                  if (col == COLW'(SCR_W - 1)) begin
                     col <= '0;
                     pg  <= pg + 1'b1;
                  end else begin
                     col <= col + 1'b1;
                  end
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/tile_map_render.sv
module tile_map_render #(
   parameter int                ADDR_W  = 24,
   parameter logic [ADDR_W-1:0] FB_BASE = 'h1000,
   parameter int                MAP_OFS = 'h360,
   parameter int                SCR_W   = 96,
   parameter int                SCR_H   = 64,
   parameter int                SW      = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [1:0]        map_size,
   input  logic [ADDR_W-1:0] tile_base,
   input  logic              invert,
   input  logic              scroll_x_wr,
   input  logic [SW-1:0]     scroll_x_data,
   input  logic              scroll_y_wr,
   input  logic [SW-1:0]     scroll_y_data,
   output logic [SW-1:0]     scroll_x,
   output logic [SW-1:0]     scroll_y,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [7:0]        mem_wdata,
   input  logic [7:0]        mem_rdata,
   output logic              busy,
   output logic              done
);
   if (SCR_H % 8 != 0 || SCR_H < 16) begin : g_bad_height
      $error("SCR_H must be a multiple of 8 and at least 16");
   end
   if (SCR_W < 2 || SCR_W > 128) begin : g_bad_width
      $error("SCR_W must lie in 2..128");
   end
   if (ADDR_W < 16) begin : g_bad_addr
      $error("ADDR_W must be at least 16");
   end

   logic [SW-1:0] org_x, org_y;
   logic [7:0]    lo_byte, hi_byte;
   logic [2:0]    shift;
   logic          inv_q;

   tmap_scroll_gate #(.SCR_W(SCR_W), .SCR_H(SCR_H), .SW(SW)) u_gate (
      .clk     (clk),
      .rst_n   (rst_n),
      .map_size(map_size),
      .wr_x    (scroll_x_wr),
      .wdata_x (scroll_x_data),
      .wr_y    (scroll_y_wr),
      .wdata_y (scroll_y_data),
      .reg_x   (scroll_x),
      .reg_y   (scroll_y),
      .org_x   (org_x),
      .org_y   (org_y)
   );

   tmap_render_seq #(
      .ADDR_W(ADDR_W), .FB_BASE(FB_BASE), .MAP_OFS(MAP_OFS),
      .SCR_W(SCR_W), .SCR_H(SCR_H), .SW(SW)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .map_size (map_size),
      .tile_base(tile_base),
      .invert   (invert),
      .org_x    (org_x),
      .org_y    (org_y),
      .mem_rdata(mem_rdata),
      .merged   (mem_wdata),
      .mem_req  (mem_req),
      .mem_we   (mem_we),
      .mem_addr (mem_addr),
      .lo_byte  (lo_byte),
      .hi_byte  (hi_byte),
      .shift    (shift),
      .inv_q    (inv_q),
      .busy     (busy),
      .done     (done)
   );

   tmap_pixel_merge u_merge (
      .lo_byte(lo_byte),
      .hi_byte(hi_byte),
      .shift  (shift),
      .invert (inv_q),
      .merged (mem_wdata)
   );
endmodule

// File: rtl/tmap_chk.sv
module tmap_chk #(
   parameter int                ADDR_W  = 24,
   parameter logic [ADDR_W-1:0] FB_BASE = 'h1000,
   parameter int                SCR_W   = 96,
   parameter int                SCR_H   = 64,
   parameter int                SW      = 7
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy,
   input logic              done,
   input logic              mem_req,
   input logic              mem_we,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              scroll_x_wr,
   input logic [SW-1:0]     scroll_x_data,
   input logic              scroll_y_wr,
   input logic [SW-1:0]     scroll_y_data,
   input logic [SW-1:0]     scroll_x,
   input logic [SW-1:0]     scroll_y,
   input logic [SW-1:0]     org_x,
   input logic [SW-1:0]     org_y
);
   localparam logic [ADDR_W-1:0] FB_END = FB_BASE + ADDR_W'(SCR_W * SCR_H / 8);

   assert_quiet_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mem_req);

   assert_raw_x_R7: assert property (@(posedge clk) disable iff (!rst_n)
      scroll_x_wr |=> scroll_x == $past(scroll_x_data));

   assert_raw_y_R7: assert property (@(posedge clk) disable iff (!rst_n)
      scroll_y_wr |=> scroll_y == $past(scroll_y_data));

   assert_org_x_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !scroll_x_wr |=> $stable(org_x));

   assert_org_y_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !scroll_y_wr |=> $stable(org_y));

   assert_fb_range_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we) |-> (mem_addr >= FB_BASE && mem_addr < FB_END));

   assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_we_with_req_R12: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> mem_req);
endmodule

bind tile_map_render tmap_chk #(
   .ADDR_W(ADDR_W), .FB_BASE(FB_BASE), .SCR_W(SCR_W), .SCR_H(SCR_H), .SW(SW)
) u_tmap_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .busy         (busy),
   .done         (done),
   .mem_req      (mem_req),
   .mem_we       (mem_we),
   .mem_addr     (mem_addr),
   .scroll_x_wr  (scroll_x_wr),
   .scroll_x_data(scroll_x_data),
   .scroll_y_wr  (scroll_y_wr),
   .scroll_y_data(scroll_y_data),
   .scroll_x     (scroll_x),
   .scroll_y     (scroll_y),
   .org_x        (org_x),
   .org_y        (org_y)
);

// File: tb/test_tile_map_render.sv
`timescale 1ns/1ps
module test_tile_map_render;
   localparam int FBB  = 'h1000;
   localparam int MAPB = 'h1360;
   localparam int TB   = 'h4000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [1:0]  map_size = 2'd0;
   logic [23:0] tile_base = 24'(TB);
   logic        invert = 1'b0;
   logic        scroll_x_wr = 1'b0, scroll_y_wr = 1'b0;
   logic [6:0]  scroll_x_data = '0, scroll_y_data = '0;
   logic [6:0]  scroll_x, scroll_y;
   logic        mem_req, mem_we, busy, done;
   logic [23:0] mem_addr;
   logic [7:0]  mem_wdata;
   logic [7:0]  mem_rdata = '0;

   logic [7:0] mem [0:65535];
   int n_chk = 0, n_err = 0;
   int cur_size = 0, m_ox = 0, m_oy = 0;
   int wr_cnt = 0, bad_wr = 0, oob_rd = 0;

   always #2 clk = ~clk;

   tile_map_render i_tile_map_render (
      .clk(clk), .rst_n(rst_n), .start(start), .map_size(map_size),
      .tile_base(tile_base), .invert(invert),
      .scroll_x_wr(scroll_x_wr), .scroll_x_data(scroll_x_data),
      .scroll_y_wr(scroll_y_wr), .scroll_y_data(scroll_y_data),
      .scroll_x(scroll_x), .scroll_y(scroll_y),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .busy(busy), .done(done)
   );

   function automatic int cols_of(input int s);
      return (s == 0) ? 12 : (s == 1) ? 16 : 24;
   endfunction
   function automatic int rows_of(input int s);
      return (s == 0) ? 16 : (s == 1) ? 12 : (s == 2) ? 8 : 16;
   endfunction

   // Memory model: read data one cycle after the request (R12).
   always @(posedge clk) begin
      if (mem_req) begin
         if (mem_we) begin
            mem[mem_addr[15:0]] <= mem_wdata;
            wr_cnt = wr_cnt + 1;
            if (int'(mem_addr) < FBB || int'(mem_addr) >= FBB + 'h300) bad_wr = bad_wr + 1;
         end else begin
            mem_rdata <= mem[mem_addr[15:0]];
            if (int'(mem_addr) >= MAPB && int'(mem_addr) < TB &&
                int'(mem_addr) >= MAPB + cols_of(cur_size) * rows_of(cur_size))
               oob_rd = oob_rd + 1;
         end
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // Reference pixel from the map and tile contents (R2..R5).
   function automatic bit map_pixel(input int x, input int y);
      int idx;
      logic [7:0] strip;
      idx   = int'(mem[MAPB + (y >> 3) * cols_of(cur_size) + (x >> 3)]);
      strip = mem[TB + idx * 8 + (x & 7)];
      return strip[y & 7];
   endfunction

   function automatic logic [7:0] exp_byte(input int p, input int c, input bit inv);
      logic [7:0] r;
      for (int b = 0; b < 8; b++) r[b] = map_pixel(m_ox + c, m_oy + 8 * p + b) ^ inv;
      return r;
   endfunction

   task automatic wr_x(input int v);
      @(negedge clk);
      scroll_x_data = 7'(v);
      scroll_x_wr   = 1'b1;
      @(negedge clk);
      scroll_x_wr = 1'b0;
      check(int'(scroll_x) == v, "R7 x read-back", int'(scroll_x), v);
      if (v + 96 <= cols_of(cur_size) * 8) m_ox = v;
   endtask

   task automatic wr_y(input int v);
      @(negedge clk);
      scroll_y_data = 7'(v);
      scroll_y_wr   = 1'b1;
      @(negedge clk);
      scroll_y_wr = 1'b0;
      check(int'(scroll_y) == v, "R7 y read-back", int'(scroll_y), v);
      if (v + 64 <= rows_of(cur_size) * 8) m_oy = v;
   endtask

   task automatic render(input bit inv, input bit chk_oob, input string tag);
      int cyc, bad, first_act, first_exp;
      @(negedge clk);
      for (int a = FBB; a < FBB + 'h300; a++) mem[a] = 8'hA5;
      invert = inv;
      wr_cnt = 0; bad_wr = 0; oob_rd = 0;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check(busy == 1'b1, "R11 busy after start", int'(busy), 1);
      cyc = 0;
      while (!done && cyc < 20000) begin
         @(negedge clk);
         cyc++;
      end
      check(done == 1'b1, "R11 done seen", int'(done), 1);
      check(wr_cnt == 768, "R11 write count", wr_cnt, 768);
      check(bad_wr == 0, "R11 writes inside frame", bad_wr, 0);
      if (chk_oob) check(oob_rd == 0, "R10 map reads in range", oob_rd, 0);
      @(negedge clk);
      check(done == 1'b0, "R11 done one cycle", int'(done), 0);
      bad = 0; first_act = 0; first_exp = 0;
      for (int p = 0; p < 8; p++)
         for (int c = 0; c < 96; c++)
            if (mem[FBB + p * 96 + c] !== exp_byte(p, c, inv)) begin
               if (bad == 0) begin
                  first_act = int'(mem[FBB + p * 96 + c]);
                  first_exp = int'(exp_byte(p, c, inv));
               end
               bad++;
            end
      check(bad == 0, tag, first_act, first_exp);
   endtask

   initial begin
      #(200000 * 4);
      n_err++;
      $display("FAIL R11 watchdog: actual 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      for (int j = 0; j < 65536; j++) mem[j] = 8'h00;
      for (int i = 0; i < 384; i++) mem[MAPB + i] = 8'(i * 37 + 11);
      for (int j = 0; j < 2048; j++) mem[TB + j] = 8'(j * 29 + (j >> 3) * 5 + 1);

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(mem_req == 1'b0, "R1 mem_req idle", int'(mem_req), 0);
      check(done == 1'b0, "R1 done low", int'(done), 0);
      check(busy == 1'b0, "R1 busy low", int'(busy), 0);
      check(scroll_x == 7'd0, "R1 scroll_x zero", int'(scroll_x), 0);
      check(scroll_y == 7'd0, "R1 scroll_y zero", int'(scroll_y), 0);

      // R2 R3 R4 R5 R12: 12x16 grid, origin (0,0) from reset
      map_size = 2'd0; cur_size = 0;
      render(1'b0, 1'b1, "R2 R3 R4 R5 R12 size0 image");

      // R6 R10: 24x16 grid, unaligned origin, inverted
      map_size = 2'd3; cur_size = 3;
      wr_x(13);
      wr_y(21);
      render(1'b1, 1'b1, "R6 R10 size3 unaligned inverted image");

      // R8: 16x12 grid boundaries
      map_size = 2'd1; cur_size = 1;
      wr_y(32);
      wr_x(32);
      wr_x(40);
      wr_y(33);
      check(m_ox == 32 && m_oy == 32, "R8 model origin", m_ox, 32);
      render(1'b0, 1'b1, "R8 size1 rejected writes image");

      // R8: 24x8 grid, x=96 accepted, x=97 rejected, y=5 rejected
      map_size = 2'd2; cur_size = 2;
      wr_y(0);
      wr_x(96);
      wr_x(97);
      wr_y(5);
      render(1'b0, 1'b1, "R2 R8 size2 boundary image");

      // R9: valid write on 24x16, then switch to 16 columns
      map_size = 2'd3; cur_size = 3;
      wr_x(50);
      wr_y(3);
      map_size = 2'd1; cur_size = 1;
      render(1'b1, 1'b0, "R9 origin kept after size change image");

      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule